// File: doc/BRIEF.md
# Critical-Word-First Cache Line Refill Sequencer

This block runs the refill of one 32-byte cache line (four doublewords) from a system bus. A per-request mode input selects the bus width: a 64-bit bus delivers one doubleword per beat, and a 32-bit bus delivers one word per beat. The requester gives the line address and the index of the doubleword that missed. The block captures these and raises a busy flag that keeps the data cache closed to new loads and stores. It then accepts data beats only in cycles where the bus marks its data as valid.

The fill begins at the missing doubleword and climbs through the line, wrapping past the last doubleword back to the first. For every accepted beat the block drives word-granular write enables, the aligned write data and the latched line address to the line storage. In the same cycle that the critical doubleword is complete in the storage, the block also presents it to the requester. A one-cycle completion pulse follows the final beat, and busy drops in the cycle after that pulse.

Top module: `line_fill_seq`

## Requirements
- R1: With the bus-width input low when a request is accepted, the fill consumes exactly four beats. Each beat writes one whole doubleword: for doubleword d, enable bits 2d (low word, write data [31:0]) and 2d+1 (high word, write data [63:32]) are set together.
- R2: With the bus-width input high when a request is accepted, the fill consumes exactly eight beats of 32 bits taken from bus data [31:0]. Each doubleword arrives on two consecutive beats, high word first (enable bit 2d+1, write data [63:32]) and low word second (enable bit 2d, write data [31:0]). Each of these beats sets a single enable bit.
- R3: Doublewords are written in the order c, c+1, c+2, c+3 modulo 4, where c is the requested doubleword index.
- R4: The critical doubleword is presented on the forward outputs, with forward-valid high for one cycle, in the same cycle as the write that completes it. In 32-bit mode this is the cycle of its low-word beat, and the forwarded value joins the held high word with that low word.
- R5: Busy is low out of reset and goes high in the cycle after a request is accepted.
- R6: A cycle in which bus data-valid is low during a fill produces no write and no forward, and it does not advance the fill. Any number of such idle cycles may fall between beats.
- R7: The done output is high for exactly one cycle, in the cycle after the final beat is consumed. Busy is still high in that cycle and is low in the next one.
- R8: A request that arrives while busy is ignored and does not change the ordering of the fill in progress. Bus beats that arrive while not busy produce no write.
- R9: Every write of a fill carries the line address captured at acceptance on the write-address output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_is_32 | input | 1 | Bus width mode, sampled when a request is accepted: 1 = 32-bit, 0 = 64-bit |
| req_valid | input | 1 | Miss request strobe |
| req_line_addr | input | ADDR_W | Line address of the miss |
| req_dw_idx | input | IDX_W | Index of the missing doubleword within the line |
| bus_valid | input | 1 | Bus data valid for this cycle |
| bus_data | input | 2*WORD_W | Bus data; only [31:0] is used in 32-bit mode |
| busy | output | 1 | Fill in progress; cache access blocked |
| done | output | 1 | One-cycle pulse after the final beat |
| wr_en | output | 2*LINE_DW | Word write enables into the line storage |
| wr_line_addr | output | ADDR_W | Line address for the storage write |
| wr_data | output | 2*WORD_W | Doubleword-aligned write data |
| fwd_valid | output | 1 | Critical doubleword forward strobe |
| fwd_data | output | 2*WORD_W | Forwarded critical doubleword |

## Verification
Writes and forwards are combinational on an accepted beat, so they are due in the cycle the beat is driven. The bench drives each beat just after a rising edge and samples at the following falling edge, before that beat is consumed. Busy is due one edge after acceptance. Done is due one edge after the final beat, and busy clears one edge after that, so the driver checks both in the cycles that follow its last beat. A scoreboard queue holds one expected write per beat, each with its forward expectation, and any write that arrives with no item waiting counts as a miscompare.

// File: rtl/lf_pkg.sv
package lf_pkg;
  typedef enum logic [1:0] {
    LF_IDLE = 2'd0,
    LF_FILL = 2'd1,
    LF_DONE = 2'd2
  } lf_state_e;
endpackage

// File: rtl/lf_beat_ctr.sv
module lf_beat_ctr #(
  parameter int LINE_DW = 4,
  localparam int BEAT_W = $clog2(2 * LINE_DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic              mode32,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              last
);
  logic [BEAT_W-1:0] cnt_q, cnt_d;
  logic [BEAT_W-1:0] final_idx;

  assign final_idx = mode32 ? BEAT_W'(2 * LINE_DW - 1) : BEAT_W'(LINE_DW - 1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = cnt_q + BEAT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign beat_idx = cnt_q;
  assign last     = adv && (cnt_q == final_idx);

  // R6: without a beat the position in the fill holds
  a_r6_hold_position: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/lf_wr_steer.sv
module lf_wr_steer #(
  parameter int LINE_DW = 4,
  localparam int IDX_W  = $clog2(LINE_DW),
  localparam int BEAT_W = $clog2(2 * LINE_DW)
) (
  input  logic              fire,
  input  logic              mode32,
  input  logic [IDX_W-1:0]  crit_idx,
  input  logic [BEAT_W-1:0] beat_idx,
  output logic [2*LINE_DW-1:0] wr_en,
  output logic              crit_upper,
  output logic              crit_done
);
  logic [IDX_W-1:0] dw_off;
  logic [IDX_W-1:0] dw_sel;
  logic             hi_ok;
  logic             lo_ok;

  // offset of the current doubleword from the critical one
  assign dw_off = mode32 ? beat_idx[BEAT_W-1:1] : beat_idx[IDX_W-1:0];
  // wraps modulo the line size (LINE_DW is a power of two)
  assign dw_sel = crit_idx + dw_off;
  assign hi_ok  = !mode32 || !beat_idx[0];
  assign lo_ok  = !mode32 ||  beat_idx[0];

  for (genvar d = 0; d < LINE_DW; d++) begin : g_dw
    assign wr_en[2*d+1] = fire && (dw_sel == IDX_W'(d)) && hi_ok;
    assign wr_en[2*d]   = fire && (dw_sel == IDX_W'(d)) && lo_ok;
  end

  assign crit_upper = fire && mode32 && (dw_off == '0) && !beat_idx[0];
  assign crit_done  = fire && (dw_off == '0) && lo_ok;
endmodule

// File: rtl/lf_fwd_hold.sv
module lf_fwd_hold #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                capture_hi,
  input  logic                crit_done,
  input  logic                mode32,
  input  logic [2*WORD_W-1:0] bus_data,
  output logic                fwd_valid,
  output logic [2*WORD_W-1:0] fwd_data
);
  logic [WORD_W-1:0] hi_q;

  // datapath register, clock-enabled, no reset needed
  always_ff @(posedge clk) begin
    if (capture_hi) hi_q <= bus_data[WORD_W-1:0];
  end

  assign fwd_valid = crit_done;
  assign fwd_data  = mode32 ? {hi_q, bus_data[WORD_W-1:0]} : bus_data;
endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq
  import lf_pkg::*;
#(
  parameter int ADDR_W  = 27,
  parameter int WORD_W  = 32,
  parameter int LINE_DW = 4,
  localparam int IDX_W  = $clog2(LINE_DW),
  localparam int BEAT_W = $clog2(2 * LINE_DW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_is_32,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_line_addr,
  input  logic [IDX_W-1:0]     req_dw_idx,
  input  logic                 bus_valid,
  input  logic [2*WORD_W-1:0]  bus_data,
  output logic                 busy,
  output logic                 done,
  output logic [2*LINE_DW-1:0] wr_en,
  output logic [ADDR_W-1:0]    wr_line_addr,
  output logic [2*WORD_W-1:0]  wr_data,
  output logic                 fwd_valid,
  output logic [2*WORD_W-1:0]  fwd_data
);
  lf_state_e         state_q, state_d;
  logic              mode32_q;
  logic [IDX_W-1:0]  crit_q;
  logic [ADDR_W-1:0] addr_q;
  logic              start;
  logic              beat_fire;
  logic              last_beat;
  logic [BEAT_W-1:0] beat_idx;
  logic              crit_upper;
  logic              crit_done;

  assign start     = (state_q == LF_IDLE) && req_valid;
  assign beat_fire = (state_q == LF_FILL) && bus_valid;

  always_comb begin
    state_d = state_q;
    case (state_q)
      LF_IDLE: if (start) state_d = LF_FILL;
      LF_FILL: if (last_beat) state_d = LF_DONE;
      LF_DONE: state_d = LF_IDLE;
      default: state_d = LF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= LF_IDLE;
      mode32_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start) mode32_q <= bus_is_32;
    end
  end

  // request capture registers, clock-enabled on acceptance
  always_ff @(posedge clk) begin
    if (start) begin
      crit_q <= req_dw_idx;
      addr_q <= req_line_addr;
    end
  end

  lf_beat_ctr #(.LINE_DW(LINE_DW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start),
    .adv      (beat_fire),
    .mode32   (mode32_q),
    .beat_idx (beat_idx),
    .last     (last_beat)
  );

  lf_wr_steer #(.LINE_DW(LINE_DW)) u_steer (
    .fire       (beat_fire),
    .mode32     (mode32_q),
    .crit_idx   (crit_q),
    .beat_idx   (beat_idx),
    .wr_en      (wr_en),
    .crit_upper (crit_upper),
    .crit_done  (crit_done)
  );

  lf_fwd_hold #(.WORD_W(WORD_W)) u_fwd (
    .clk        (clk),
    .capture_hi (crit_upper),
    .crit_done  (crit_done),
    .mode32     (mode32_q),
    .bus_data   (bus_data),
    .fwd_valid  (fwd_valid),
    .fwd_data   (fwd_data)
  );

  assign busy         = (state_q != LF_IDLE);
  assign done         = (state_q == LF_DONE);
  assign wr_line_addr = addr_q;
  assign wr_data      = mode32_q ? {bus_data[WORD_W-1:0], bus_data[WORD_W-1:0]} : bus_data;

  a_r1_full_dw_write: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && !mode32_q) |-> ($countones(wr_en) == 2));

  a_r2_single_word_write: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && mode32_q) |-> ($countones(wr_en) == 1));

  a_r4_fwd_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> wr_en[{crit_q, 1'b0}]);

  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  a_r7_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

  a_r8_no_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (wr_en == '0));
endmodule

// File: tb/line_fill_seq_bench.sv
module line_fill_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_is_32;
  logic        req_valid;
  logic [26:0] req_line_addr;
  logic [1:0]  req_dw_idx;
  logic        bus_valid;
  logic [63:0] bus_data;
  logic        busy, done, fwd_valid;
  logic [7:0]  wr_en;
  logic [26:0] wr_line_addr;
  logic [63:0] wr_data, fwd_data;

  always #2 clk = ~clk;

  line_fill_seq u_line_fill_seq (
    .clk(clk), .rst_n(rst_n), .bus_is_32(bus_is_32), .req_valid(req_valid),
    .req_line_addr(req_line_addr), .req_dw_idx(req_dw_idx),
    .bus_valid(bus_valid), .bus_data(bus_data), .busy(busy), .done(done),
    .wr_en(wr_en), .wr_line_addr(wr_line_addr), .wr_data(wr_data),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data)
  );

  typedef struct {
    logic [7:0]  en;
    logic [63:0] data;
    logic        fwd;
    logic [63:0] fdata;
  } item_t;

  item_t       exp_q[$];
  int          vectors = 0;
  int          errors  = 0;
  logic [26:0] cur_addr;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input int fill, input int w);
    return 32'hC0DE0000 ^ (32'(fill) << 8) ^ 32'(w);
  endfunction

  // monitor: compare every write the design issues against the queue
  always @(negedge clk) begin
    if (rst_n === 1'b1 && (wr_en != 8'h00 || fwd_valid)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6/R8", "unexpected write", {56'h0, wr_en}, 64'h0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(wr_en == it.en, "R1/R2/R3", "write enables", {56'h0, wr_en}, {56'h0, it.en});
        if (|(it.en & 8'hAA))
          chk(wr_data[63:32] == it.data[63:32], "R1/R2", "high word", wr_data, it.data);
        if (|(it.en & 8'h55))
          chk(wr_data[31:0] == it.data[31:0], "R1/R2", "low word", wr_data, it.data);
        chk(wr_line_addr == cur_addr, "R9", "line address", {37'h0, wr_line_addr}, {37'h0, cur_addr});
        chk(fwd_valid == it.fwd, "R4", "forward strobe", {63'h0, fwd_valid}, {63'h0, it.fwd});
        if (it.fwd)
          chk(fwd_data == it.fdata, "R4", "forward data", fwd_data, it.fdata);
      end
    end
  end

  task automatic gap_cycles(input int n, input bit poke, input int crit);
    for (int g = 0; g < n; g++) begin
      bus_valid = 1'b0;
      bus_data  = 64'hDEAD_BEEF_0BAD_F00D ^ 64'(g);
      if (poke) begin
        req_valid     = 1'b1;
        req_dw_idx    = 2'(crit + 1);
        req_line_addr = ~cur_addr;
      end
      #1;
      chk(wr_en == 8'h00 && !fwd_valid, "R6", "idle cycle write", {56'h0, wr_en}, 64'h0);
      @(posedge clk); #1;
    end
    req_valid = 1'b0;
  endtask

  task automatic beat(input logic [63:0] d, input item_t it);
    bus_valid = 1'b1;
    bus_data  = d;
    exp_q.push_back(it);
    @(posedge clk); #1;
    bus_valid = 1'b0;
  endtask

  task automatic run_fill(input bit m32, input int crit, input int gap,
                          input int fill, input logic [26:0] addr, input bit poke);
    item_t it;
    @(posedge clk); #1;
    bus_is_32     = m32;
    req_valid     = 1'b1;
    req_dw_idx    = 2'(crit);
    req_line_addr = addr;
    cur_addr      = addr;
    @(posedge clk); #1;
    req_valid = 1'b0;
    bus_is_32 = ~m32; // mode is latched at acceptance
    chk(busy == 1'b1, "R5", "busy after accept", {63'h0, busy}, 64'h1);
    for (int k = 0; k < 4; k++) begin
      int d;
      logic [31:0] hi, lo;
      d  = (crit + k) % 4;
      hi = word_of(fill, 2*d+1);
      lo = word_of(fill, 2*d);
      gap_cycles(gap, poke, crit);
      if (!m32) begin
        it.en = 8'b11 << (2*d); it.data = {hi, lo};
        it.fwd = (k == 0); it.fdata = {hi, lo};
        beat({hi, lo}, it);
      end else begin
        it.en = 8'b1 << (2*d+1); it.data = {hi, 32'h0};
        it.fwd = 1'b0; it.fdata = 64'h0;
        beat({32'h5A5A_5A5A, hi}, it);
        gap_cycles(gap, poke, crit);
        it.en = 8'b1 << (2*d); it.data = {32'h0, lo};
        it.fwd = (k == 0); it.fdata = {hi, lo};
        beat({32'hA5A5_A5A5, lo}, it);
      end
    end
    chk(done == 1'b1, "R7", "done after last beat", {63'h0, done}, 64'h1);
    chk(busy == 1'b1, "R7", "busy during done", {63'h0, busy}, 64'h1);
    @(posedge clk); #1;
    chk(done == 1'b0, "R7", "done one cycle", {63'h0, done}, 64'h0);
    chk(busy == 1'b0, "R7", "busy released", {63'h0, busy}, 64'h0);
    chk(exp_q.size() == 0, "R1/R2", "beats left over", 64'(exp_q.size()), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_is_32 = 1'b0; req_valid = 1'b0; req_line_addr = '0;
    req_dw_idx = '0; bus_valid = 1'b0; bus_data = '0; cur_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(busy == 1'b0 && done == 1'b0, "R5", "reset state", {62'h0, busy, done}, 64'h0);
    chk(wr_en == 8'h00 && !fwd_valid, "R8", "reset writes", {56'h0, wr_en}, 64'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R8: beats while idle are ignored
    for (int i = 0; i < 3; i++) begin
      bus_valid = 1'b1; bus_data = 64'h1111_2222_3333_4444 + 64'(i);
      #1;
      chk(wr_en == 8'h00 && !busy, "R8", "idle beat write", {56'h0, wr_en}, 64'h0);
      @(posedge clk); #1;
    end
    bus_valid = 1'b0;

    run_fill(1'b0, 0, 0, 1, 27'h0123456, 1'b0); // R1 R3
    run_fill(1'b0, 2, 1, 2, 27'h7654321, 1'b0); // R3 wrap, R6 gaps
    run_fill(1'b0, 3, 2, 3, 27'h0AAAAAA, 1'b1); // R8 request while busy
    run_fill(1'b1, 0, 0, 4, 27'h1555555, 1'b0); // R2
    run_fill(1'b1, 1, 2, 5, 27'h2000001, 1'b0); // R2 R4 R6
    run_fill(1'b1, 3, 1, 6, 27'h3FFFFFF, 1'b1); // R2 R3 R8
    run_fill(1'b0, 1, 0, 7, 27'h0000000, 1'b0); // mode back to 64

    repeat (2) @(posedge clk);
    #1;
    chk(busy == 1'b0, "R8", "no fill after ignored request", {63'h0, busy}, 64'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule